// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This unit narrows a 32-bit IEEE-754 binary32 operand to a 16-bit binary16 result in one registered stage. Each accepted operand carries a 3-bit rounding-mode code. One code defers to a separately supplied dynamic mode. The unit returns the narrowed value with a 5-bit vector of accrued exception flags, which the surrounding floating-point pipeline merges into its own status.

Every class of input is covered. NaNs collapse to one canonical pattern, and infinities and zeros keep their sign. Normal values are rebiased and rounded. Values too small for the binary16 normal range are shifted into subnormals, with guard and sticky information kept, and a rounding carry may lift them back into the normal range. Values too large saturate to infinity or to the largest finite magnitude, as the mode and the sign dictate. Reserved mode codes are flagged on a separate error output and handled as round-to-nearest-even.

Top module: `sp2hp_cvt`

## Requirements
- R1: A result appears on the outputs, with `out_valid` high, exactly one clock after a cycle with `in_valid` high. `out_valid` is low after a cycle with `in_valid` low, and it is low while reset is asserted.
- R2: Any NaN input (exponent all ones, fraction nonzero) yields 0x7E00. The invalid flag (bit 4) is set only when fraction bit 22 is 0, which marks a signaling NaN.
- R3: An infinite input yields 0x7C00 carrying the input's sign, and a zero yields a zero of the input's sign. Neither raises any flag.
- R4: Finite results are rounded by the effective mode: 000 nearest-even, 001 toward zero, 010 toward negative, 011 toward positive, 100 nearest with ties away from zero.
- R5: On overflow, before or after rounding, the overflow flag (bit 2) and the inexact flag (bit 0) are set. The result is infinity for the two nearest modes. It is 0x7BFF in magnitude for toward-zero, for toward-negative with a positive sign, and for toward-positive with a negative sign. The other sign in those two directed modes gives infinity.
- R6: Code 111 selects `dyn_rm` as the effective mode. An effective code of 101, 110 or 111 sets `out_rm_err` and is handled as nearest-even.
- R7: Results below the normal range are subnormals, rounded at the binary16 subnormal LSB. A carry out of 0x3FF produces the smallest normal, 0x0400.
- R8: The underflow flag (bit 1) is set when the result is inexact and the rebiased exponent before rounding is 0 or below. This includes the case where rounding carries the result into the normal range.
- R9: The inexact flag is set exactly when the result differs from the input value. Exact conversions, including the smallest subnormal and the smallest normal, raise no flag.
- R10: The flag vector is {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 to bit 0, and divide-by-zero is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 32 | binary32 operand |
| in_rm | input | 3 | Rounding-mode code carried with the operand |
| dyn_rm | input | 3 | Dynamic rounding mode used when `in_rm` is 111 |
| out_valid | output | 1 | Result present |
| out_res | output | 16 | binary16 result |
| out_flags | output | 5 | {invalid, div-zero, overflow, underflow, inexact} |
| out_rm_err | output | 1 | Effective rounding mode was reserved |

## Verification
Several properties are checked on every cycle by the assertions, whatever the operand:
- the one-cycle valid timing;
- the canonical NaN pattern, and the invalid flag appearing only with it;
- overflow and underflow always coming with inexact;
- the divide-by-zero bit staying clear;
- infinities and zeros passing through with their sign.

Only the bench's directed vectors can show the exact rounded values, for several reasons. Each mode rounds differently at ties. Saturation depends on the mode and sign together. The carry from the largest subnormal into 0x0400 must be exercised directly. And only chosen operands separate tininess from plain inexactness.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;
  localparam int SRC_EW = 8;
  localparam int SRC_MW = 23;
  localparam int DST_EW = 5;
  localparam int DST_MW = 10;
  localparam int SRC_W  = 1 + SRC_EW + SRC_MW;
  localparam int DST_W  = 1 + DST_EW + DST_MW;
  localparam int RM_W   = 3;
  localparam int FLG_W  = 5;

  typedef enum logic [RM_W-1:0] {
    RM_RNE = 3'd0,
    RM_RTZ = 3'd1,
    RM_RDN = 3'd2,
    RM_RUP = 3'd3,
    RM_RMM = 3'd4,
    RM_DYN = 3'd7
  } rmode_e;

  typedef struct packed {
    logic nv;
    logic dz;
    logic of;
    logic uf;
    logic nx;
  } fflags_t;
endpackage

// File: rtl/sp2hp_rm_sel.sv
module sp2hp_rm_sel
  import sp2hp_pkg::*;
(
  input  logic [RM_W-1:0] instr_rm,
  input  logic [RM_W-1:0] dyn_rm,
  output rmode_e          rm_eff,
  output logic            illegal
);
  logic [RM_W-1:0] picked;

  always_comb begin
    picked = (instr_rm == RM_DYN) ? dyn_rm : instr_rm;
    illegal = 1'b0;
    case (picked)
      RM_RNE, RM_RTZ, RM_RDN, RM_RUP, RM_RMM: rm_eff = rmode_e'(picked);
      default: begin
        // reserved codes (R6) fall back to nearest-even
        rm_eff  = RM_RNE;
        illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sp2hp_rnd_inc.sv
module sp2hp_rnd_inc
  import sp2hp_pkg::*;
(
  input  rmode_e rm,
  input  logic   sgn,
  input  logic   lsb,
  input  logic   guard,
  input  logic   sticky,
  output logic   inc
);
  logic lost;

  always_comb begin
    lost = guard | sticky;
    case (rm)
      RM_RTZ:  inc = 1'b0;
      RM_RDN:  inc = sgn & lost;
      RM_RUP:  inc = ~sgn & lost;
      RM_RMM:  inc = guard;
      default: inc = guard & (sticky | lsb);
    endcase
  end
endmodule

// File: rtl/sp2hp_core.sv
module sp2hp_core
  import sp2hp_pkg::*;
#(
  parameter int SE = SRC_EW,
  parameter int SM = SRC_MW,
  parameter int DE = DST_EW,
  parameter int DM = DST_MW
) (
  input  logic [SE+SM:0] op_i,
  input  rmode_e         rm,
  output logic [DE+DM:0] res_o,
  output fflags_t        flags_o
);
  localparam int SBIAS     = (1 << (SE - 1)) - 1;
  localparam int DBIAS     = (1 << (DE - 1)) - 1;
  localparam int BIAS_DIFF = SBIAS - DBIAS;
  localparam int NSH       = SM - DM;
  localparam int SHMAX     = SM + 3;
  localparam int SHW       = $clog2(SHMAX + 1);
  localparam int WLW       = SHMAX + DM;
  localparam int HEW       = SE + 2;
  localparam int DEMAX     = (1 << DE) - 1;

  logic                  sgn;
  logic [SE-1:0]         ex;
  logic [SM-1:0]         mn;
  logic                  is_spec, is_nan, is_inf, is_zero;
  logic [SM:0]           sig;
  logic signed [HEW-1:0] he;
  logic [SHW-1:0]        sh;
  logic [WLW-1:0]        wide;
  logic [DM-1:0]         kept;
  logic                  guard, sticky, tiny, big, inc, to_inf, ovf;
  logic [DE+DM-1:0]      base;
  logic [DE+DM:0]        sum;

  localparam logic [DE+DM-1:0] MAXFIN = {{(DE-1){1'b1}}, 1'b0, {DM{1'b1}}};
  localparam logic [DE+DM-1:0] INFMAG = {{DE{1'b1}}, {DM{1'b0}}};
  localparam logic [DE+DM:0]   QNAN   = {1'b0, {DE{1'b1}}, 1'b1, {(DM-1){1'b0}}};

  assign sgn     = op_i[SE+SM];
  assign ex      = op_i[SE+SM-1:SM];
  assign mn      = op_i[SM-1:0];
  assign is_spec = &ex;
  assign is_nan  = is_spec & (|mn);
  assign is_inf  = is_spec & ~(|mn);
  assign is_zero = ~(|ex) & ~(|mn);
  assign sig     = {|ex, mn};
  assign he      = signed'({2'b00, ex}) - signed'(HEW'(BIAS_DIFF));
  assign tiny    = (he <= 0);
  assign big     = (he >= DEMAX);

  // alignment distance: fixed for normals, grows below the normal range
  always_comb begin
    int shi;
    if (he > 0) shi = NSH;
    else begin
      shi = NSH + 1 - int'(he);
      if (shi > SHMAX) shi = SHMAX;
    end
    sh = SHW'(shi);
  end

  assign wide   = WLW'({sig, {SHMAX{1'b0}}} >> sh);
  assign kept   = wide[WLW-1:SHMAX];
  assign guard  = wide[SHMAX-1];
  assign sticky = |wide[SHMAX-2:0];
  assign base   = tiny ? {{DE{1'b0}}, kept} : {he[DE-1:0], kept};

  sp2hp_rnd_inc u_inc (
    .rm     (rm),
    .sgn    (sgn),
    .lsb    (kept[0]),
    .guard  (guard),
    .sticky (sticky),
    .inc    (inc)
  );

  assign sum = {1'b0, base} + (DE+DM+1)'(inc);
  assign ovf = big | sum[DE+DM] | (&sum[DE+DM-1:DM]);

  always_comb begin
    case (rm)
      RM_RTZ:  to_inf = 1'b0;
      RM_RDN:  to_inf = sgn;
      RM_RUP:  to_inf = ~sgn;
      default: to_inf = 1'b1;
    endcase
  end

  always_comb begin
    flags_o = '0;
    if (is_nan) begin
      res_o      = QNAN;
      flags_o.nv = ~mn[SM-1];
    end else if (is_inf) begin
      res_o = {sgn, INFMAG};
    end else if (is_zero) begin
      res_o = {sgn, {(DE+DM){1'b0}}};
    end else if (ovf) begin
      res_o      = {sgn, to_inf ? INFMAG : MAXFIN};
      flags_o.of = 1'b1;
      flags_o.nx = 1'b1;
    end else begin
      res_o      = {sgn, sum[DE+DM-1:0]};
      flags_o.nx = guard | sticky;
      flags_o.uf = (guard | sticky) & tiny;
    end
  end
endmodule

// File: rtl/sp2hp_cvt.sv
module sp2hp_cvt
  import sp2hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] in_op,
  input  logic [RM_W-1:0]  in_rm,
  input  logic [RM_W-1:0]  dyn_rm,
  output logic             out_valid,
  output logic [DST_W-1:0] out_res,
  output logic [FLG_W-1:0] out_flags,
  output logic             out_rm_err
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  rmode_e           rm_eff;
  logic             rm_bad;
  logic [DST_W-1:0] core_res;
  fflags_t          core_flags;

  logic             valid_d, valid_q;
  logic [DST_W-1:0] res_d, res_q;
  logic [FLG_W-1:0] flg_d, flg_q;
  logic             err_d, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sp2hp_rm_sel u_rm (
    .instr_rm (in_rm),
    .dyn_rm   (dyn_rm),
    .rm_eff   (rm_eff),
    .illegal  (rm_bad)
  );

  sp2hp_core #(
    .SE (SRC_EW),
    .SM (SRC_MW),
    .DE (DST_EW),
    .DM (DST_MW)
  ) u_core (
    .op_i    (in_op),
    .rm      (rm_eff),
    .res_o   (core_res),
    .flags_o (core_flags)
  );

  always_comb begin
    valid_d = in_valid;
    res_d   = in_valid ? core_res : res_q;
    flg_d   = in_valid ? FLG_W'(core_flags) : flg_q;
    err_d   = in_valid ? rm_bad : err_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    res_q <= res_d;
    flg_q <= flg_d;
    err_q <= err_d;
  end

  assign out_valid  = valid_q;
  assign out_res    = res_q;
  assign out_flags  = flg_q;
  assign out_rm_err = err_q;
endmodule

// File: rtl/sp2hp_cvt_chk.sv
module sp2hp_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_op,
  input logic        out_valid,
  input logic [15:0] out_res,
  input logic [4:0]  out_flags
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_dz_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flags[3]);

  a_r2_nan_canonical: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_res[14:10]) && (|out_res[9:0])) |-> out_res == 16'h7E00);

  a_r2_nv_only_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[4]) |-> (out_res == 16'h7E00 && out_flags[3:0] == 4'b0));

  a_r5_of_with_nx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> (out_flags[0] && !out_flags[1]));

  a_r8_uf_with_nx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> out_flags[0]);

  a_r3_inf_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[30:0] == 31'h7F800000)
      |=> (out_res == {$past(in_op[31]), 15'h7C00} && out_flags == 5'b0));

  a_r3_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[30:0] == 31'h0)
      |=> (out_res == {$past(in_op[31]), 15'h0} && out_flags == 5'b0));
endmodule

bind sp2hp_cvt sp2hp_cvt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_res   (out_res),
  .out_flags (out_flags)
);

// File: tb/test_sp2hp_cvt.sv
module test_sp2hp_cvt;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_op;
  logic [2:0]  in_rm;
  logic [2:0]  dyn_rm;
  logic        out_valid;
  logic [15:0] out_res;
  logic [4:0]  out_flags;
  logic        out_rm_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  sp2hp_cvt i_sp2hp_cvt (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_rm      (in_rm),
    .dyn_rm     (dyn_rm),
    .out_valid  (out_valid),
    .out_res    (out_res),
    .out_flags  (out_flags),
    .out_rm_err (out_rm_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fields: req, operand, rm, dyn, expected result, expected flags, expected err
  localparam int NV = 42;
  localparam logic [63:0] VEC [NV] = '{
    // R4 rounding modes
    {4'd4,  32'h3F800000, 3'd0, 3'd0, 16'h3C00, 5'h00, 1'b0},
    {4'd4,  32'hC0000000, 3'd0, 3'd0, 16'hC000, 5'h00, 1'b0},
    {4'd4,  32'h3F801000, 3'd0, 3'd0, 16'h3C00, 5'h01, 1'b0},
    {4'd4,  32'h3F801000, 3'd3, 3'd0, 16'h3C01, 5'h01, 1'b0},
    {4'd4,  32'h3F801000, 3'd4, 3'd0, 16'h3C01, 5'h01, 1'b0},
    {4'd4,  32'h3F801000, 3'd1, 3'd0, 16'h3C00, 5'h01, 1'b0},
    {4'd4,  32'h3F803000, 3'd0, 3'd0, 16'h3C02, 5'h01, 1'b0},
    {4'd4,  32'h3F803000, 3'd1, 3'd0, 16'h3C01, 5'h01, 1'b0},
    {4'd4,  32'hBF801001, 3'd2, 3'd0, 16'hBC01, 5'h01, 1'b0},
    {4'd4,  32'hBF801001, 3'd3, 3'd0, 16'hBC00, 5'h01, 1'b0},
    {4'd4,  32'h3F801001, 3'd0, 3'd0, 16'h3C01, 5'h01, 1'b0},
    // R5 overflow saturation
    {4'd5,  32'h47800000, 3'd0, 3'd0, 16'h7C00, 5'h05, 1'b0},
    {4'd5,  32'h47800000, 3'd1, 3'd0, 16'h7BFF, 5'h05, 1'b0},
    {4'd5,  32'h47800000, 3'd2, 3'd0, 16'h7BFF, 5'h05, 1'b0},
    {4'd5,  32'hC7800000, 3'd2, 3'd0, 16'hFC00, 5'h05, 1'b0},
    {4'd5,  32'hC7800000, 3'd3, 3'd0, 16'hFBFF, 5'h05, 1'b0},
    {4'd5,  32'h47800000, 3'd3, 3'd0, 16'h7C00, 5'h05, 1'b0},
    {4'd5,  32'h477FF000, 3'd0, 3'd0, 16'h7C00, 5'h05, 1'b0},
    {4'd5,  32'h477FF000, 3'd1, 3'd0, 16'h7BFF, 5'h01, 1'b0},
    // R9 exact smallest subnormal, R8 underflow cases
    {4'd9,  32'h33800000, 3'd0, 3'd0, 16'h0001, 5'h00, 1'b0},
    {4'd8,  32'h33000000, 3'd0, 3'd0, 16'h0000, 5'h03, 1'b0},
    {4'd8,  32'h33000000, 3'd3, 3'd0, 16'h0001, 5'h03, 1'b0},
    // R7 carry from largest subnormal into smallest normal
    {4'd7,  32'h387FF000, 3'd0, 3'd0, 16'h0400, 5'h03, 1'b0},
    {4'd7,  32'h387FF000, 3'd1, 3'd0, 16'h03FF, 5'h03, 1'b0},
    {4'd8,  32'h00000001, 3'd3, 3'd0, 16'h0001, 5'h03, 1'b0},
    {4'd8,  32'h00000001, 3'd0, 3'd0, 16'h0000, 5'h03, 1'b0},
    {4'd8,  32'h80000001, 3'd2, 3'd0, 16'h8001, 5'h03, 1'b0},
    // R2 NaNs
    {4'd2,  32'h7F800001, 3'd0, 3'd0, 16'h7E00, 5'h10, 1'b0},
    {4'd2,  32'h7FC00000, 3'd0, 3'd0, 16'h7E00, 5'h00, 1'b0},
    {4'd2,  32'hFFC00001, 3'd0, 3'd0, 16'h7E00, 5'h00, 1'b0},
    // R3 infinities and zeros
    {4'd3,  32'h7F800000, 3'd0, 3'd0, 16'h7C00, 5'h00, 1'b0},
    {4'd3,  32'hFF800000, 3'd2, 3'd0, 16'hFC00, 5'h00, 1'b0},
    {4'd3,  32'h80000000, 3'd0, 3'd0, 16'h8000, 5'h00, 1'b0},
    {4'd3,  32'h00000000, 3'd3, 3'd0, 16'h0000, 5'h00, 1'b0},
    // R6 dynamic and reserved modes
    {4'd6,  32'h3F803000, 3'd7, 3'd1, 16'h3C01, 5'h01, 1'b0},
    {4'd6,  32'h3F801000, 3'd7, 3'd3, 16'h3C01, 5'h01, 1'b0},
    {4'd6,  32'h3F801000, 3'd5, 3'd0, 16'h3C00, 5'h01, 1'b1},
    {4'd6,  32'h47800000, 3'd6, 3'd1, 16'h7C00, 5'h05, 1'b1},
    {4'd6,  32'h3F801000, 3'd7, 3'd6, 16'h3C00, 5'h01, 1'b1},
    // R9 exact conversions
    {4'd9,  32'h38800000, 3'd1, 3'd0, 16'h0400, 5'h00, 1'b0},
    {4'd9,  32'h42480000, 3'd0, 3'd0, 16'h5240, 5'h00, 1'b0},
    // R10 flag layout: invalid at bit 4 only
    {4'd10, 32'h7F800001, 3'd3, 3'd0, 16'h7E00, 5'h10, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_op    = '0;
    in_rm    = '0;
    dyn_rm   = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", {31'b0, out_valid}, 32'd0, "valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle cycle gives no valid
    @(posedge clk); #2;
    check("R1", {31'b0, out_valid}, 32'd0, "valid while idle");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = VEC[i][59:28];
      in_rm    = VEC[i][27:25];
      dyn_rm   = VEC[i][24:22];
      @(posedge clk); #2;
      check($sformatf("R%0d", VEC[i][63:60]),
            {9'b0, out_valid, out_res, out_flags, out_rm_err},
            {9'b0, 1'b1, VEC[i][21:0]},
            $sformatf("vec %0d {valid,res,flags,err}", i));
    end

    // R1: drop in_valid, output valid must fall one cycle later
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #2;
    check("R1", {31'b0, out_valid}, 32'd0, "valid after idle");

    // R1: reset in mid-stream clears valid at once
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = 32'h3F800000;
    in_rm    = 3'd0;
    @(posedge clk); #2;
    check("R1", {15'b0, out_valid, out_res}, {15'b0, 1'b1, 16'h3C00}, "valid before reset");
    rst_n = 1'b0;
    #1;
    check("R1", {31'b0, out_valid}, 32'd0, "valid on reset");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (3) @(negedge clk);

    // R3: negative zero after reset recovery, R10 dz bit
    in_valid = 1'b1;
    in_op    = 32'h80000000;
    in_rm    = 3'd1;
    @(posedge clk); #2;
    check("R3", {10'b0, out_valid, out_res, out_flags}, {10'b0, 1'b1, 16'h8000, 5'h00}, "neg zero");
    @(negedge clk);
    in_valid = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule